// File: doc/BRIEF.md
# Eight-Channel Input Interrupt Controller

This block watches a set of asynchronous digital input lines and raises one interrupt request toward a host when a configured condition is seen on any of them. Each line first passes through a two-stage synchronizer. Each channel can be set to one of two interrupt types. The first is a level type, which fires while the synchronized input equals a programmed polarity. The second is a change-of-state type, which fires on any rising or falling transition. Per-channel pending flags collect these events. The host clears them by writing ones to the status register. A level condition that is still present sets its flag again at once.

Registers are byte-addressed behind a simple select/write strobe bus. The bus is 16 bits wide. Control registers occupy the low byte and always read zero in the upper byte. A small acknowledge state machine handles the interrupt-select cycle. While an acknowledge is granted, the 8-bit vector register is placed on the read data bus. Its states are ACK_IDLE (no request), ACK_ARMED (request raised) and ACK_GRANT (vector driven). Its transitions are:

- ACK_IDLE to ACK_ARMED when the request rises.
- ACK_ARMED to ACK_GRANT when int_sel is high while the request is still present.
- ACK_ARMED to ACK_IDLE when the request falls.
- ACK_GRANT stays put while int_sel is high.
- When int_sel drops, ACK_GRANT returns to ACK_ARMED if the request remains, or to ACK_IDLE if it does not.

The channel count NCH may be set from 1 to 8.

Top module: `chint_ctrl`

## Requirements
- R1: After reset, every register reads 0x0000, `irq` is 0 and `vec_valid` is 0.
- R2: On a channel with type bit 1 (change-of-state), both a rising and a falling input transition set that channel's status bit.
- R3: On a channel with type bit 0 (level), polarity bit 0 sets the status bit while the input is low, and polarity bit 1 sets it while the input is high. On a change-of-state channel, a steady input sets nothing, whatever its polarity bit.
- R4: A channel whose enable bit is 0 never sets its status bit, under either type.
- R5: Writing status bit n = 1 clears flag n. Writing 0 leaves flag n unchanged.
- R6: If a level condition is still present when its flag is cleared, the flag reads 1 again right after the clearing write.
- R7: If an event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R8: `irq` is 1 exactly when some channel has both its enable bit and its status bit at 1. Clearing an enable bit masks `irq` but keeps that channel's status bit.
- R9: The vector register is read/write. While `irq` is high, holding `int_sel` high raises `vec_valid` one cycle later, with the vector on `bus_rdata[7:0]`, and keeps it high until `int_sel` drops. `int_sel` with no request never raises `vec_valid`.
- R10: Register offsets are enable 0x09, type 0x0D, status 0x0F, polarity 0x11 and vector 0x13, with bit n controlling channel n. Reads return 0 in bits 15:8. Written bits 15:8 are ignored. Unmapped offsets read 0.
- R11: An input change reaches the status register on the third rising clock edge after it is applied: two synchronizer stages, then the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NCH | Asynchronous input lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, or the vector during a grant |
| int_sel | input | 1 | Interrupt-select acknowledge |
| irq | output | 1 | Interrupt request |
| vec_valid | output | 1 | Vector is on bus_rdata |

## Verification
A fresh event and a host write-one-to-clear can land on the same flag bit in the same cycle. The bench provokes this by toggling a change-of-state input at the exact point where the clearing write is sampled on the third edge after the toggle. It then requires the bit to still read 1, and to clear on a later write. The same clash arises naturally for a persistent level condition, which must read back as set after every clear until the input moves away from the polarity.

// File: rtl/chint_pkg.sv
package chint_pkg;
    localparam int ADDR_W = 8;
    localparam int VEC_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_EN   = 8'h09;
    localparam logic [ADDR_W-1:0] ADR_TYPE = 8'h0D;
    localparam logic [ADDR_W-1:0] ADR_STAT = 8'h0F;
    localparam logic [ADDR_W-1:0] ADR_POL  = 8'h11;
    localparam logic [ADDR_W-1:0] ADR_VEC  = 8'h13;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_ARMED = 2'd1,
        ACK_GRANT = 2'd2
    } ack_st_t;
endpackage

// File: rtl/chint_sync.sv
module chint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            sync <= '0;
        end else begin
            meta <= raw;
            sync <= meta;
        end
    end
endmodule

// File: rtl/chint_event.sv
module chint_event #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] en,
    input  logic [W-1:0] typ,
    input  logic [W-1:0] pol,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_ch
        always_comb begin
            if (typ[i]) evt[i] = en[i] & (cur[i] ^ prev[i]);
            else        evt[i] = en[i] & (cur[i] == pol[i]);
        end
    end
endmodule

// File: rtl/chint_regs.sv
module chint_regs #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [chint_pkg::ADDR_W-1:0]  bus_addr,
    input  logic [DW-1:0]                 bus_wdata,
    input  logic [NCH-1:0]                evt,
    output logic [NCH-1:0]                en,
    output logic [NCH-1:0]                typ,
    output logic [NCH-1:0]                pol,
    output logic [NCH-1:0]                pend,
    output logic [chint_pkg::VEC_W-1:0]   vec,
    output logic [DW-1:0]                 reg_rdata
);
    import chint_pkg::*;

    logic           wr_hit;
    logic [NCH-1:0] clr;

    assign wr_hit = bus_sel && bus_wr;
    assign clr    = (wr_hit && bus_addr == ADR_STAT) ? bus_wdata[NCH-1:0] : '0;

    if (DW > VEC_W) begin : g_hi
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DW-1:VEC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en  <= '0;
            typ <= '0;
            pol <= '0;
            vec <= '0;
        end else if (wr_hit) begin
            case (bus_addr)
                ADR_EN:   en  <= bus_wdata[NCH-1:0];
                ADR_TYPE: typ <= bus_wdata[NCH-1:0];
                ADR_POL:  pol <= bus_wdata[NCH-1:0];
                ADR_VEC:  vec <= bus_wdata[VEC_W-1:0];
                default:  ;
            endcase
        end
    end

    // set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | evt;
    end

    always_comb begin
        reg_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADR_EN:   reg_rdata = DW'(en);
                ADR_TYPE: reg_rdata = DW'(typ);
                ADR_STAT: reg_rdata = DW'(pend);
                ADR_POL:  reg_rdata = DW'(pol);
                ADR_VEC:  reg_rdata = DW'(vec);
                default:  reg_rdata = '0;
            endcase
        end
    end

    p_no_set_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(en)) == '0));

    p_only_w1c_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~pend & ~$past(clr)) == '0));

    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/chint_ack.sv
module chint_ack (
    input  logic clk,
    input  logic rst_n,
    input  logic irq,
    input  logic int_sel,
    output logic vec_valid
);
    import chint_pkg::*;

    ack_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ACK_IDLE:  nxt = irq ? ACK_ARMED : ACK_IDLE;
            ACK_ARMED: begin
                if (!irq)         nxt = ACK_IDLE;
                else if (int_sel) nxt = ACK_GRANT;
                else              nxt = ACK_ARMED;
            end
            ACK_GRANT: begin
                if (int_sel)  nxt = ACK_GRANT;
                else if (irq) nxt = ACK_ARMED;
                else          nxt = ACK_IDLE;
            end
            default:   nxt = ACK_IDLE;
        endcase
    end

    always_comb begin
        vec_valid = (state == ACK_GRANT);
    end

    p_grant_after_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(irq));

    p_grant_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && int_sel) |=> vec_valid);
endmodule

// File: rtl/chint_ctrl.sv
module chint_ctrl #(
    parameter int NCH = 8,
    parameter int DW  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0]               pin_in,
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [chint_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]                bus_wdata,
    output logic [DW-1:0]                bus_rdata,
    input  logic                         int_sel,
    output logic                         irq,
    output logic                         vec_valid
);
    import chint_pkg::*;

    logic [NCH-1:0]   cur, evt, en, typ, pol, pend;
    logic [VEC_W-1:0] vec;
    logic [DW-1:0]    reg_rdata;

    chint_sync #(.W(NCH)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .sync(cur)
    );

    chint_event #(.W(NCH)) u_event (
        .clk(clk), .rst_n(rst_n), .cur(cur), .en(en), .typ(typ),
        .pol(pol), .evt(evt)
    );

    chint_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt),
        .en(en), .typ(typ), .pol(pol), .pend(pend), .vec(vec),
        .reg_rdata(reg_rdata)
    );

    assign irq = |(pend & en);

    chint_ack u_ack (
        .clk(clk), .rst_n(rst_n), .irq(irq), .int_sel(int_sel),
        .vec_valid(vec_valid)
    );

    assign bus_rdata = vec_valid ? DW'(vec) : reg_rdata;
endmodule

// File: tb/tb_chint_ctrl.sv
module tb_chint_ctrl;
    localparam logic [7:0] A_EN = 8'h09, A_TY = 8'h0D, A_ST = 8'h0F,
                           A_PO = 8'h11, A_VE = 8'h13;

    logic        clk = 0, rst_n = 0;
    logic [7:0]  pin_in = '0;
    logic        bus_sel = 0, bus_wr = 0, int_sel = 0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, vec_valid;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    chint_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_sel(int_sel), .irq(irq),
        .vec_valid(vec_valid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic quiet();
        wr(A_EN, 16'h0);
        wr(A_TY, 16'h0);
        wr(A_PO, 16'h0);
        wr(A_ST, 16'hFFFF);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk);
        rd(A_EN, v); check("R1 en", v, 0);
        rd(A_TY, v); check("R1 type", v, 0);
        rd(A_ST, v); check("R1 status", v, 0);
        rd(A_PO, v); check("R1 pol", v, 0);
        rd(A_VE, v); check("R1 vec", v, 0);
        check("R1 irq", {15'b0, irq}, 0);
        check("R1 vec_valid", {15'b0, vec_valid}, 0);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(A_PO, 16'hFF5C);
        rd(A_PO, v); check("R10 upper zero", v, 16'h005C);
        rd(8'h0E, v); check("R10 unmapped", v, 0);
        wr(8'h0E, 16'hFFFF);
        rd(A_EN, v); check("R10 unmapped write", v, 0);
        rd(A_TY, v); check("R10 unmapped write type", v, 0);
        wr(A_PO, 16'h0);
    endtask

    task automatic t_latency();
        logic [15:0] v;
        quiet();
        wr(A_TY, 16'h08); wr(A_EN, 16'h08); wr(A_ST, 16'hFF);
        cyc(3);
        pin_in[3] = 1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        rd(A_ST, v); check("R11 not before third edge", v, 0);
        @(posedge clk); @(negedge clk);
        rd(A_ST, v); check("R11 third edge", v, 16'h0008);
        pin_in[3] = 0; cyc(4);
    endtask

    task automatic t_cos();
        logic [15:0] v;
        quiet();
        wr(A_TY, 16'h01); wr(A_EN, 16'h01); wr(A_ST, 16'hFF);
        pin_in[0] = 1; cyc(3);
        rd(A_ST, v); check("R2 rising", v, 16'h0001);
        wr(A_ST, 16'h01);
        rd(A_ST, v); check("R3 cos steady high, pol 0", v, 0);
        wr(A_PO, 16'h01); cyc(3);
        rd(A_ST, v); check("R3 cos steady high, pol 1", v, 0);
        pin_in[0] = 0; cyc(3);
        rd(A_ST, v); check("R2 falling", v, 16'h0001);
        wr(A_ST, 16'h01);
    endtask

    task automatic t_level();
        logic [15:0] v;
        quiet();
        pin_in[1] = 0; pin_in[2] = 1; cyc(3);
        wr(A_PO, 16'h04); wr(A_EN, 16'h06); cyc(1);
        rd(A_ST, v); check("R3 low and high level", v, 16'h0006);
        pin_in[1] = 1; pin_in[2] = 0; cyc(3);
        wr(A_ST, 16'h06);
        rd(A_ST, v); check("R3 level condition gone", v, 0);
        pin_in = '0; cyc(3);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        quiet();
        cyc(4);
        rd(A_ST, v); check("R4 disabled level", v, 0);
        wr(A_TY, 16'hFF);
        pin_in = 8'hFF; cyc(4);
        rd(A_ST, v); check("R4 disabled cos", v, 0);
        check("R4 irq", {15'b0, irq}, 0);
        pin_in = '0; cyc(4);
    endtask

    task automatic t_w1c();
        logic [15:0] v;
        quiet();
        wr(A_TY, 16'h09); wr(A_EN, 16'h09); wr(A_ST, 16'hFF);
        pin_in[0] = 1; pin_in[3] = 1; cyc(3);
        rd(A_ST, v); check("R5 set", v, 16'h0009);
        wr(A_ST, 16'h0000);
        rd(A_ST, v); check("R5 write zero keeps", v, 16'h0009);
        wr(A_ST, 16'h0008);
        rd(A_ST, v); check("R5 clear one bit", v, 16'h0001);
        wr(A_ST, 16'hFF01);
        rd(A_ST, v); check("R5 clear rest", v, 0);
        pin_in = '0; cyc(3);
        wr(A_ST, 16'hFF);
    endtask

    task automatic t_persist();
        logic [15:0] v;
        quiet();
        pin_in[1] = 0;
        wr(A_EN, 16'h02); cyc(1);
        wr(A_ST, 16'h02);
        rd(A_ST, v); check("R6 level re-sets", v, 16'h0002);
        check("R6 irq held", {15'b0, irq}, 1);
        pin_in[1] = 1; cyc(3);
        wr(A_ST, 16'h02);
        rd(A_ST, v); check("R6 clears once gone", v, 0);
        pin_in = '0; cyc(3);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        quiet();
        wr(A_TY, 16'h01); wr(A_EN, 16'h01); wr(A_ST, 16'hFF);
        pin_in[0] = 1; cyc(3);
        rd(A_ST, v); check("R7 setup", v, 16'h0001);
        pin_in[0] = 0;
        @(posedge clk);
        @(posedge clk);
        wr(A_ST, 16'h01);
        rd(A_ST, v); check("R7 set wins over clear", v, 16'h0001);
        wr(A_ST, 16'h01);
        rd(A_ST, v); check("R7 later clear", v, 0);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        quiet();
        pin_in[1] = 0;
        wr(A_EN, 16'h02); cyc(1);
        check("R8 irq on", {15'b0, irq}, 1);
        wr(A_EN, 16'h00);
        check("R8 irq masked", {15'b0, irq}, 0);
        rd(A_ST, v); check("R8 flag kept", v, 16'h0002);
        wr(A_EN, 16'h02);
        check("R8 irq back", {15'b0, irq}, 1);
    endtask

    task automatic t_ack();
        logic [15:0] v;
        wr(A_VE, 16'hFF5A);
        rd(A_VE, v); check("R9 vector rw", v, 16'h005A);
        cyc(2);
        int_sel = 1;
        check("R9 not yet", {15'b0, vec_valid}, 0);
        cyc(1);
        check("R9 granted", {15'b0, vec_valid}, 1);
        check("R9 vector on bus", bus_rdata, 16'h005A);
        cyc(1);
        check("R9 held", {15'b0, vec_valid}, 1);
        int_sel = 0; cyc(1);
        check("R9 released", {15'b0, vec_valid}, 0);
        quiet();
        cyc(2);
        check("R9 no request", {15'b0, irq}, 0);
        int_sel = 1; cyc(2);
        check("R9 spurious select", {15'b0, vec_valid}, 0);
        int_sel = 0; cyc(1);
    endtask

    initial begin
        #(200000 * 20);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_map();
        t_latency();
        t_cos();
        t_level();
        t_disabled();
        t_w1c();
        t_persist();
        t_collide();
        t_mask();
        t_ack();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule